// File: doc/BRIEF.md
# SEC-DED Cache Line Refill Engine

This block fills a small direct-mapped cache from an external memory whose words each carry 32 data bits and 7 check bits. It decodes every arriving word with a single-error-correcting, double-error-detecting code in the same cycle the word arrives, and stores the corrected value into a line store that keeps one valid bit per word. When a word cannot be corrected during a fill, only that word's valid bit stays clear. The other words of the line are still written. No error is raised unless that word is the one the requester asked for.

A later request for a word whose valid bit is clear is a miss on a resident line. It fetches only that word again. If the word is still uncorrectable, the error is returned with that response. A correctable or clean refetch makes the word valid. The same code is exposed as a combinational encoder, which the memory write path uses to produce check bits.

Top module: `linefill_ecc`

## Requirements
- R1: A codeword places data in bits [31:0] and check bits in [38:32]. The encoder passes data through unchanged. It is linear, so encoding zero gives zero and encode(a^b) = encode(a)^encode(b). Each data bit's check-bit column has odd weight of at least 3, and all 32 columns are distinct.
- R2: Flipping any one of the 39 codeword bits still returns the original data with no error flag. The corrected value is the one stored for later hits.
- R3: When the demanded word holds a double-bit error, the response carries rsp_err=1 and rsp_data=0.
- R4: A request to a line index that is absent, or that holds another tag, allocates the line and reads all 4 words in ascending order from offset 0. A word address is {tag[7:4], index[3:2], offset[1:0]}.
- R5: The response to a miss appears in the cycle after the memory beat of the demanded word, even while later words of the line are still pending.
- R6: An uncorrectable word that was not demanded raises no error. Its valid bit stays clear, and every other word of the line is still filled and later hits.
- R7: A request to a word whose valid bit is clear, in a resident line, performs exactly one memory read, at that word's address.
- R8: If a refetched word is uncorrectable, the error is reported and the word stays invalid, so the next request refetches it again. A clean or correctable refetch sets the word valid, and the next request hits.
- R9: A hit responds in the cycle after the request is accepted and reads no memory.
- R10: ce_pulse is high for exactly one cycle for each corrected word, including errors in the check bits. It stays low for clean words and for uncorrectable words.
- R11: While reset is held and after it is released, req_ready=1, rsp_valid=0 and mem_req=0, and no line is resident.
- R12: req_ready is low from the acceptance of a miss until its last memory beat. Requests offered in that time are ignored and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_addr | input | 8 | Word address of the request |
| req_ready | output | 1 | Engine idle; a request is taken on this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Corrected data (zero on error) |
| rsp_err | output | 1 | Demanded word uncorrectable |
| mem_req | output | 1 | Memory read outstanding |
| mem_addr | output | 8 | Word address being read |
| mem_rvalid | input | 1 | Memory returns the codeword for mem_addr |
| mem_rcode | input | 39 | Returned codeword |
| ce_pulse | output | 1 | A word was corrected |
| enc_data | input | 32 | Data to encode for memory writes |
| enc_code | output | 39 | Codeword for enc_data |

## Verification
The embedded properties watch, on every cycle, that a read address is held until its beat and steps by one between the beats of a fill, and that an error flag never appears without a response. They also check that a hit answers next cycle without memory traffic, that a memory read never overlaps an idle engine, that a valid bit never exists in an absent line, and that allocation clears all valid bits. The bench scenarios cover the behaviour that needs chosen data and injected faults: correction of every one of the 39 bit positions, silence about uncorrectable speculative words, single-word refetch that fails repeatedly and then succeeds after memory is repaired, and eviction on a tag change.

// File: rtl/lfe_pkg.sv
// Package: shared constants, state type and the SEC-DED parity-check matrix.
// Assumes 32 data bits and 7 check bits; each data column is a weight-3
// 7-bit vector, taken in ascending numeric order (35 exist, first 32 used).
package lfe_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } lfe_state_t;

    // Build the packed column table: column i sits at [i*CHK_W +: CHK_W].
    function automatic logic [DATA_W*CHK_W-1:0] lfe_build_cols();
        logic [DATA_W*CHK_W-1:0] t;
        int k;
        t = '0;
        k = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(CHK_W'(v)) == 3 && k < DATA_W) begin
                t[k*CHK_W +: CHK_W] = CHK_W'(v);
                k++;
            end
        end
        return t;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] LFE_COLS = lfe_build_cols();

    // Check bits of a data word: XOR of the columns of its set bits.
    function automatic logic [CHK_W-1:0] lfe_check_bits(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) c = c ^ LFE_COLS[i*CHK_W +: CHK_W];
        end
        return c;
    endfunction

endpackage

// File: rtl/lfe_encoder.sv
// Encoder: forms the 39-bit codeword {check, data} for the memory write path.
// Purely combinational; shares the matrix with the decoder via lfe_pkg.
module lfe_encoder
    import lfe_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    // Append the check bits above the data bits.
    always_comb begin
        code_o = {lfe_check_bits(data_i), data_i};
    end

endmodule

// File: rtl/lfe_decoder.sv
// Decoder: recomputes the check bits, forms the syndrome and corrects a
// single-bit error. Assumes codeword layout {check[6:0], data[31:0]}.
// ce_o: one bit was wrong (data or check); ue_o: uncorrectable pattern.
module lfe_decoder
    import lfe_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o
);

    logic [CHK_W-1:0] syn;
    logic             col_match;

    // Syndrome, single-bit correction and error classification.
    always_comb begin
        syn       = lfe_check_bits(code_i[DATA_W-1:0]) ^ code_i[CODE_W-1:DATA_W];
        data_o    = code_i[DATA_W-1:0];
        col_match = 1'b0;
        ce_o      = 1'b0;
        ue_o      = 1'b0;
        if (syn != '0) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (LFE_COLS[i*CHK_W +: CHK_W] == syn) begin
                    data_o[i] = ~code_i[i];
                    col_match = 1'b1;
                end
            end
            if (col_match || $countones(syn) == 1) ce_o = 1'b1;
            else                                   ue_o = 1'b1;
        end
    end

endmodule

// File: rtl/lfe_line_store.sv
// Line store: direct-mapped tag, presence and data arrays with one valid bit
// per word. Allocation sets the tag and clears every valid bit of the line.
// Assumes LINES and WORDS are powers of two; allocation and word writes
// never occur in the same cycle.
module lfe_line_store #(
    parameter int LINES = 4,
    parameter int WORDS = 4,
    parameter int TAG_W = 4,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [$clog2(LINES)-1:0] alloc_idx,
    input  logic [TAG_W-1:0]         alloc_tag,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [$clog2(WORDS)-1:0] wr_off,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr_valid,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    input  logic [$clog2(WORDS)-1:0] rd_off,
    output logic                     rd_present,
    output logic [TAG_W-1:0]         rd_tag,
    output logic                     rd_word_valid,
    output logic [DW-1:0]            rd_data
);

    localparam int IDX_W   = $clog2(LINES);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int ENTRIES = LINES * WORDS;

    logic [DW-1:0]    data_q  [ENTRIES];
    logic [TAG_W-1:0] tag_q   [LINES];
    logic [WORDS-1:0] vbits_q [LINES];
    logic [LINES-1:0] present_q;

    // Control state per line: presence, tag and per-word valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
            for (int l = 0; l < LINES; l++) begin
                tag_q[l]   <= '0;
                vbits_q[l] <= '0;
            end
        end else if (alloc_en) begin
            present_q[alloc_idx] <= 1'b1;
            tag_q[alloc_idx]     <= alloc_tag;
            vbits_q[alloc_idx]   <= '0;
        end else if (wr_en) begin
            vbits_q[wr_idx][wr_off] <= wr_valid;
        end
    end

    // Data array: written on every fill beat, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[{wr_idx, wr_off}] <= wr_data;
    end

    // Lookup port.
    always_comb begin
        rd_present    = present_q[rd_idx];
        rd_tag        = tag_q[rd_idx];
        rd_word_valid = vbits_q[rd_idx][rd_off];
        rd_data       = data_q[{rd_idx, rd_off}];
    end

    // Allocation leaves the line with no valid word (R4).
    p_alloc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (vbits_q[$past(alloc_idx)] == '0));

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line_chk
            // A valid word only exists inside a resident line (R6).
            p_valid_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (|vbits_q[l]) |-> present_q[l]);
        end
    endgenerate

    // Unused-width guard: IDX_W/OFF_W shape the flat index above.
    initial begin
        if (ENTRIES != (1 << (IDX_W + OFF_W)))
            $error("lfe_line_store: LINES and WORDS must be powers of two");
    end

endmodule

// File: rtl/linefill_ecc.sv
// Top: refill sequencer. Looks up the store on an accepted request; a hit
// answers next cycle, an absent line is fully refilled from offset 0, and
// an invalid word of a resident line is refetched alone. Every beat is
// decoded in its arrival cycle; only the demanded word may report an error.
// Assumes memory returns one codeword per mem_req/mem_rvalid handshake for
// the address shown on mem_addr.
module linefill_ecc
    import lfe_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [CODE_W-1:0] mem_rcode,
    output logic              ce_pulse,
    input  logic [DATA_W-1:0] enc_data,
    output logic [CODE_W-1:0] enc_code
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    lfe_state_t       st_q;
    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] dem_q;
    logic [OFF_W-1:0] fetch_q;
    logic [OFF_W-1:0] last_q;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             accept;
    logic             rd_present;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_word_valid;
    logic [DATA_W-1:0] rd_data;
    logic             line_match;
    logic             hit;
    logic             alloc_en;
    logic             beat;
    logic [DATA_W-1:0] dec_data;
    logic             dec_ce;
    logic             dec_ue;

    // Request address fields and lookup outcome.
    always_comb begin
        req_off    = req_addr[OFF_W-1:0];
        req_idx    = req_addr[OFF_W +: IDX_W];
        req_tag    = req_addr[ADDR_W-1 -: TAG_W];
        req_ready  = (st_q == ST_IDLE);
        accept     = req_valid && req_ready;
        line_match = rd_present && (rd_tag == req_tag);
        hit        = line_match && rd_word_valid;
        alloc_en   = accept && !line_match;
        mem_req    = (st_q == ST_FETCH);
        mem_addr   = {tag_q, idx_q, fetch_q};
        beat       = mem_req && mem_rvalid;
    end

    lfe_encoder u_enc (
        .data_i (enc_data),
        .code_o (enc_code)
    );

    lfe_decoder u_dec (
        .code_i (mem_rcode),
        .data_o (dec_data),
        .ce_o   (dec_ce),
        .ue_o   (dec_ue)
    );

    lfe_line_store #(
        .LINES (LINES),
        .WORDS (WORDS),
        .TAG_W (TAG_W),
        .DW    (DATA_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_en      (alloc_en),
        .alloc_idx     (req_idx),
        .alloc_tag     (req_tag),
        .wr_en         (beat),
        .wr_idx        (idx_q),
        .wr_off        (fetch_q),
        .wr_data       (dec_data),
        .wr_valid      (!dec_ue),
        .rd_idx        (req_idx),
        .rd_off        (req_off),
        .rd_present    (rd_present),
        .rd_tag        (rd_tag),
        .rd_word_valid (rd_word_valid),
        .rd_data       (rd_data)
    );

    // Sequencer: lookup in idle, one word per beat while fetching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            tag_q     <= '0;
            idx_q     <= '0;
            dem_q     <= '0;
            fetch_q   <= '0;
            last_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
            ce_pulse  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            ce_pulse  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        tag_q <= req_tag;
                        idx_q <= req_idx;
                        dem_q <= req_off;
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= rd_data;
                        end else if (line_match) begin
                            fetch_q <= req_off;
                            last_q  <= req_off;
                            st_q    <= ST_FETCH;
                        end else begin
                            fetch_q <= '0;
                            last_q  <= LAST_OFF;
                            st_q    <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        ce_pulse <= dec_ce;
                        if (fetch_q == dem_q) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= dec_ue;
                            rsp_data  <= dec_ue ? '0 : dec_data;
                        end
                        if (fetch_q == last_q) st_q    <= ST_IDLE;
                        else                   fetch_q <= fetch_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Read address is held until its beat arrives (R4).
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // Consecutive beats of one fill walk upward by one word (R4).
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (!mem_req || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // The error flag only travels with a response (R3).
    p_err_with_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // Hit answers next cycle without a memory read (R9).
    p_hit_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (rsp_valid && !mem_req));

    // No request is taken while a read is outstanding (R12).
    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // A corrected word never also reports as uncorrectable (R10).
    p_ce_excl_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && rsp_err));

endmodule

// File: tb/linefill_ecc_test.sv
// Scoreboard bench: the access task queues the expected response, a monitor
// pops and compares responses, and logs memory beats and correction pulses.
module linefill_ecc_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [7:0]  req_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        mem_req;
    logic [7:0]  mem_addr;
    logic        mem_rvalid;
    logic [38:0] mem_rcode;
    logic        ce_pulse;
    logic [31:0] enc_data;
    logic [38:0] enc_code;

    always #5 clk = ~clk;

    linefill_ecc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_err    (rsp_err),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rcode  (mem_rcode),
        .ce_pulse   (ce_pulse),
        .enc_data   (enc_data),
        .enc_code   (enc_code)
    );

    typedef struct {
        logic [7:0]  a;
        logic [31:0] d;
        bit          e;
        string       rq;
    } exp_t;

    exp_t        expq[$];
    logic [7:0]  beats[$];
    logic [31:0] mdata [256];
    logic [38:0] mbase [256];
    logic [38:0] mmask [256];
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    int          ce_n;
    int          rsp_cyc;
    int          dem_cyc;
    bit          rsp_in_fill;
    logic [7:0]  cur_a;
    int          wcnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic encode(input logic [31:0] d, output logic [38:0] c);
        enc_data = d;
        #1;
        c = enc_code;
    endtask

    // Memory model: a codeword two cycles after each read becomes outstanding.
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            mem_rvalid = 1'b0;
            wcnt = 0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (mem_req) begin
            wcnt++;
            if (wcnt >= 2) begin
                mem_rvalid = 1'b1;
                mem_rcode  = mbase[mem_addr] ^ mmask[mem_addr];
                wcnt = 0;
            end
        end else begin
            wcnt = 0;
        end
    end

    // Monitor: scoreboard compare, beat log, correction pulse count.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_cyc     = cyc;
            rsp_in_fill = mem_req;
            if (expq.size() == 0) begin
                check(1'b0, "R12", "unexpected response", {32'h0, rsp_data}, 64'h0);
            end else begin
                exp_t x;
                x = expq.pop_front();
                check(rsp_err == x.e, x.rq, "error flag", 64'(rsp_err), 64'(x.e));
                check(rsp_data == x.d, x.rq, "data", 64'(rsp_data), 64'(x.d));
            end
        end
        if (rst_n && mem_req && mem_rvalid) begin
            beats.push_back(mem_addr);
            if (mem_addr == cur_a) dem_cyc = cyc;
        end
        if (rst_n && ce_pulse) ce_n++;
    end

    // Driver: one access with its expected response, beat count and pulses.
    task automatic access(input logic [7:0] a, input bit e, input int nbeats,
                          input int nce, input string rq, input bit poke);
        exp_t x;
        int   acc;
        bit   ok;
        x.a = a; x.d = e ? 32'h0 : mdata[a]; x.e = e; x.rq = rq;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        beats.delete();
        ce_n  = 0;
        cur_a = a;
        expq.push_back(x);
        req_valid = 1'b1;
        req_addr  = a;
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            check(!req_ready, "R12", "ready during fill", 64'(req_ready), 64'h0);
            req_valid = 1'b1;
            req_addr  = a ^ 8'h80;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!(req_ready && expq.size() == 0)) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(beats.size() == nbeats, rq, "beat count", 64'(beats.size()), 64'(nbeats));
        if (nbeats == 4 && beats.size() == 4) begin
            ok = 1'b1;
            for (int k = 0; k < 4; k++)
                if (beats[k] != {a[7:2], 2'(k)}) ok = 1'b0;
            check(ok, "R4", "ascending line order", 64'(beats[0]), 64'({a[7:2], 2'b00}));
            if (a[1:0] != 2'd3)
                check(rsp_in_fill, "R5", "response before fill end", 64'(rsp_in_fill), 64'h1);
        end
        if (nbeats == 1 && beats.size() == 1)
            check(beats[0] == a, "R7", "refetch address", 64'(beats[0]), 64'(a));
        if (nbeats > 0)
            check(rsp_cyc == dem_cyc + 1, "R5", "response cycle", 64'(rsp_cyc - dem_cyc), 64'h1);
        else
            check(rsp_cyc == acc + 1, "R9", "hit latency", 64'(rsp_cyc - acc), 64'h1);
        check(ce_n == nce, rq, "correction pulses", 64'(ce_n), 64'(nce));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

    initial begin
        logic [38:0] c, ca, cb, cab;
        logic [6:0]  cols [32];
        bit          ok;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        mem_rvalid = 1'b0; mem_rcode = '0; enc_data = '0;

        // R1: encoder layout, columns and linearity.
        encode(32'h0, c);
        check(c == 39'h0, "R1", "encode zero", 64'(c), 64'h0);
        ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            encode(32'h1 << i, c);
            cols[i] = c[38:32];
            if (c[31:0] != (32'h1 << i)) ok = 1'b0;
            if (($countones(c[38:32]) % 2) != 1 || $countones(c[38:32]) < 3) ok = 1'b0;
            for (int j = 0; j < i; j++) if (cols[j] == cols[i]) ok = 1'b0;
        end
        check(ok, "R1", "column shape", 64'(ok), 64'h1);
        encode(32'hA5C3_0F19, ca);
        encode(32'h1E2D_3C4B, cb);
        encode(32'hA5C3_0F19 ^ 32'h1E2D_3C4B, cab);
        check(cab == (ca ^ cb), "R1", "linearity", 64'(cab), 64'(ca ^ cb));

        for (int a = 0; a < 256; a++) begin
            mdata[a] = 32'h1234_5678 ^ (32'(a) * 32'h9E37_79B9) ^ (32'(a) << 20);
            encode(mdata[a], mbase[a]);
            mmask[a] = '0;
        end

        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R11", "outputs in reset",
              {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R11", "outputs after reset",
              {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);

        // Clean line fill on an empty cache (R4, R11), then hits (R9).
        access(8'h10, 1'b0, 4, 0, "R4", 1'b0);
        access(8'h12, 1'b0, 0, 0, "R9", 1'b0);
        access(8'h13, 1'b0, 0, 0, "R9", 1'b0);

        // Single-bit errors in data and check bits of one line (R2, R10).
        mmask[8'h24] = 39'h1;
        mmask[8'h25] = 39'h1 << 38;
        mmask[8'h26] = 39'h1 << 17;
        access(8'h26, 1'b0, 4, 3, "R10", 1'b0);
        mmask[8'h24] = '0; mmask[8'h25] = '0; mmask[8'h26] = '0;
        access(8'h24, 1'b0, 0, 0, "R2", 1'b0);
        access(8'h25, 1'b0, 0, 0, "R2", 1'b0);

        // Uncorrectable speculative word stays silent and invalid (R6).
        mmask[8'h39] = (39'h1 << 3) | (39'h1 << 20);
        access(8'h38, 1'b0, 4, 0, "R6", 1'b0);
        access(8'h3A, 1'b0, 0, 0, "R6", 1'b0);
        access(8'h3B, 1'b0, 0, 0, "R6", 1'b0);
        // Demand on it: single refetch, still bad, reported (R7, R8).
        access(8'h39, 1'b1, 1, 0, "R8", 1'b0);
        access(8'h39, 1'b1, 1, 0, "R8", 1'b0);
        // Memory repaired: refetch succeeds, then hits (R8).
        mmask[8'h39] = '0;
        access(8'h39, 1'b0, 1, 0, "R7", 1'b0);
        access(8'h39, 1'b0, 0, 0, "R8", 1'b0);

        // Double errors on the demanded word (R3).
        mmask[8'h4D] = (39'h1 << 32) | (39'h1 << 33);
        mmask[8'h4E] = 39'h3;
        access(8'h4D, 1'b1, 4, 0, "R3", 1'b0);
        access(8'h4E, 1'b1, 1, 0, "R3", 1'b0);
        mmask[8'h4D] = '0; mmask[8'h4E] = '0;

        // Tag change evicts; requests during the fill are ignored (R4, R12).
        access(8'h50, 1'b0, 4, 0, "R4", 1'b1);
        access(8'h10, 1'b0, 4, 0, "R4", 1'b1);
        access(8'h11, 1'b0, 0, 0, "R9", 1'b0);

        // Every codeword bit position corrected on a demand fill (R2, R10).
        for (int b = 0; b < 39; b++) begin
            logic [7:0] a;
            a = {((b % 2) == 1) ? 4'h7 : 4'h6, 2'b00, 2'(b % 4)};
            mmask[a] = 39'h1 << b;
            access(a, 1'b0, 4, 1, "R2", 1'b0);
            mmask[a] = '0;
        end

        finish_run();
    end

endmodule